// File: doc/BRIEF.md
# Flash Read-While-Write Access Gate

This block sits in front of a flash array and decides, for each page read, whether that read may go ahead. The flash can be idle, running a high-voltage program or erase, or holding one of those operations in suspend. Reads are served while the array is idle. Reads are also served during a high-voltage operation, provided they land in a partition that the operation does not touch. A read into a partition that is being programmed or erased is refused. It returns an error and sets a sticky read-while-write error flag that software clears.

The read path is a valid/ready stream. A request carries a page address, and the response carries one full 128-bit page, an error bit, or both. The page contents come from an arithmetic array model, so no storage is needed. The program, erase, suspend and enable controls live in a 32-bit register. A read-only status register mirrors the high-voltage flag and the partition mask, both of which are inputs. Register space outside these two words reads as zero, and writes to it are dropped.

Back-pressure rules: a request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response stays valid, with its data and error bit unchanged, until `rsp_ready` is seen high.

Top module: `flash_rww_gate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and the control register reads as 0, including the sticky error bit.
- R2: While the enable bit (CTRL bit 0) is 0, every read responds with `rsp_err`=1 and all-zero data, and the sticky error bit is left unchanged.
- R3: When the array is enabled and both program (CTRL bit 1) and erase (CTRL bit 2) are 0, a read returns `rsp_err`=0. The data is made of four 32-bit words: word k (bits 32k+31..32k) equals {8'hA0+k, zero padding, page address}.
- R4: When program or erase is set and `hv_active` is 1, a read whose partition bit in `op_part_mask` is 0 returns page data without error.
- R5: When program or erase is set and `hv_active` is 1, a read whose partition bit in `op_part_mask` is 1 returns `rsp_err`=1 with zero data, and sets the sticky error bit (CTRL bit 8). Rule R6 takes precedence over this rule.
- R6: A read is served without error, whatever the mask and `hv_active`, in two cases: program and program-suspend (CTRL bit 3) are both 1, or erase and erase-suspend (CTRL bit 4) are 1 while program is 0.
- R7: When program or erase is set, `hv_active` is 0 and neither case of R6 holds, a read returns `rsp_err`=1 with zero data, and the sticky error bit is left unchanged.
- R8: A response is valid on the cycle after its request is accepted. It is held stable, with `req_ready` low, while `rsp_ready` is 0.
- R9: The sticky error bit is cleared only by a CTRL write with bit 8 set. A write with bit 8 clear leaves it as it was. If a conflicting read and a clearing write fall on the same edge, the bit ends up set.
- R10: Register offset 0x0 is CTRL. Offset 0x4 is read-only status, with `op_part_mask` in bits 3..0 and `hv_active` in bit 4. Every other address, including unaligned ones, reads as 0, and writes there or to status leave CTRL unchanged.
- R11: The partition of a read is the top two bits of its 8-bit page address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| req_addr | input | 8 | Page address of the read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 128 | Page data, zero on error |
| rsp_err | output | 1 | Read was refused |
| hv_active | input | 1 | High-voltage operation in progress |
| op_part_mask | input | 4 | Partitions under program or erase |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
Two events can land on the same clock edge: a refused read that sets the sticky error bit, and a register write that clears it. The bench drives both on one edge, with the write clearing bit 8 and the read aimed at a masked partition. It then reads CTRL and expects the bit to be set. It also checks the opposite pairing, where a clearing write meets a harmless read and the bit must end up clear. A separate back-pressure case holds a second request against a stalled response. It judges that the first page stays on the outputs and that the second page follows once the stall is released.

// File: rtl/flash_rww_pkg.sv
package flash_rww_pkg;

  typedef struct packed {
    logic esus;
    logic psus;
    logic ers;
    logic pgm;
    logic en;
  } fctl_t;

  typedef enum logic [1:0] {
    ACC_GRANT    = 2'd0,
    ACC_DISABLED = 2'd1,
    ACC_BUSY     = 2'd2,
    ACC_CONFLICT = 2'd3
  } acc_t;

  localparam int CTL_BITS   = 5;
  localparam int STICKY_BIT = 8;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_STAT   = 4;

endpackage

// File: rtl/rww_access_policy.sv
module rww_access_policy
  import flash_rww_pkg::*;
#(
  parameter int PART_N = 4,
  localparam int PART_W = (PART_N > 1) ? $clog2(PART_N) : 1
) (
  input  fctl_t             ctl,
  input  logic              hv_active,
  input  logic [PART_N-1:0] op_mask,
  input  logic [PART_W-1:0] part_idx,
  output acc_t              verdict
);

  logic op_running;
  logic in_suspend;
  logic part_hit;

  always_comb begin
    op_running = ctl.pgm | ctl.ers;
    in_suspend = (ctl.pgm & ctl.psus) | (ctl.ers & ctl.esus & ~ctl.pgm);
    part_hit   = op_mask[part_idx];
  end

  always_comb begin
    if (!ctl.en)           verdict = ACC_DISABLED;
    else if (!op_running)  verdict = ACC_GRANT;
    else if (in_suspend)   verdict = ACC_GRANT;
    else if (hv_active)    verdict = part_hit ? ACC_CONFLICT : ACC_GRANT;
    else                   verdict = ACC_BUSY;
  end

endmodule

// File: rtl/rww_page_model.sv
module rww_page_model #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 128,
  parameter int WORD_W = 32,
  localparam int WORDS = DATA_W / WORD_W,
  localparam int PAD_W = WORD_W - 8 - ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] page
);

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam logic [7:0] TAG = 8'(8'hA0 + k);
    if (PAD_W > 0) begin : g_pad
      assign page[k*WORD_W +: WORD_W] = {TAG, {PAD_W{1'b0}}, addr};
    end else begin : g_nopad
      assign page[k*WORD_W +: WORD_W] = {TAG, addr};
    end
  end

endmodule

// File: rtl/rww_ctrl_regs.sv
module rww_ctrl_regs
  import flash_rww_pkg::*;
#(
  parameter int PART_N = 4,
  parameter int REG_AW = 4,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rwe_set,
  input  logic              hv_active,
  input  logic [PART_N-1:0] op_mask,
  output fctl_t             ctl,
  output logic              rwe,
  output logic [REG_W-1:0]  rdata
);

  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);

  logic hit_ctrl, hit_stat, wr_ctrl, w1c;

  assign hit_ctrl = (addr == A_CTRL);
  assign hit_stat = (addr == A_STAT);
  assign wr_ctrl  = wr_en & hit_ctrl;
  assign w1c      = wr_ctrl & wdata[STICKY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_ctrl) begin
      ctl <= fctl_t'(wdata[CTL_BITS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rwe <= 1'b0;
    else if (rwe_set) rwe <= 1'b1;
    else if (w1c)     rwe <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[CTL_BITS-1:0] = ctl;
      rdata[STICKY_BIT]   = rwe;
    end else if (hit_stat) begin
      rdata[PART_N-1:0] = op_mask;
      rdata[PART_N]     = hv_active;
    end
  end

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rwe && !w1c) |=> rwe);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rwe_set |=> rwe);
  p_ctrl_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctl));

endmodule

// File: rtl/flash_rww_gate.sv
module flash_rww_gate
  import flash_rww_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 128,
  parameter int PART_N = 4,
  parameter int REG_AW = 4,
  parameter int REG_W  = 32,
  localparam int PART_W = (PART_N > 1) ? $clog2(PART_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic              hv_active,
  input  logic [PART_N-1:0] op_part_mask,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);

  fctl_t             ctl;
  logic              rwe;
  acc_t              verdict;
  logic [DATA_W-1:0] page;
  logic [PART_W-1:0] part_idx;
  logic              accept;
  logic              rwe_set;

  assign part_idx  = req_addr[ADDR_W-1 -: PART_W];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rwe_set   = accept && (verdict == ACC_CONFLICT);

  rww_access_policy #(.PART_N(PART_N)) u_policy (
    .ctl       (ctl),
    .hv_active (hv_active),
    .op_mask   (op_part_mask),
    .part_idx  (part_idx),
    .verdict   (verdict)
  );

  rww_page_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_page (
    .addr (req_addr),
    .page (page)
  );

  rww_ctrl_regs #(.PART_N(PART_N), .REG_AW(REG_AW), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rwe_set   (rwe_set),
    .hv_active (hv_active),
    .op_mask   (op_part_mask),
    .ctl       (ctl),
    .rwe       (rwe),
    .rdata     (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= (verdict != ACC_GRANT);
      rsp_data  <= (verdict == ACC_GRANT) ? page : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));
  p_conflict_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rwe_set |=> rsp_err);

endmodule

// File: tb/tb_flash_rww_gate.sv
module tb_flash_rww_gate;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0;
  logic         req_valid = 0, rsp_ready = 1;
  logic         req_ready, rsp_valid, rsp_err;
  logic [7:0]   req_addr = 0;
  logic [127:0] rsp_data;
  logic         hv_active = 0;
  logic [3:0]   op_part_mask = 0;
  logic         reg_wr_en = 0;
  logic [3:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0;
  logic [31:0]  reg_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rww_gate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .hv_active(hv_active),
    .op_part_mask(op_part_mask), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_page(input logic [7:0] a);
    logic [127:0] p;
    for (int k = 0; k < 4; k++) p[k*32 +: 32] = {8'(8'hA0 + k), 16'h0, a};
    return p;
  endfunction

  // expected {err, sticky_set} from the requirement rules
  function automatic logic [1:0] exp_acc(input logic [4:0] c, input logic hv,
                                         input logic [3:0] m, input logic [1:0] part);
    logic en, pgm, ers, psus, esus;
    {esus, psus, ers, pgm, en} = c;
    if (!en) return 2'b10;                               // R2
    if (!pgm && !ers) return 2'b00;                      // R3
    if ((pgm && psus) || (ers && esus && !pgm)) return 2'b00; // R6
    if (hv) return m[part] ? 2'b11 : 2'b00;              // R4 R5 R11
    return 2'b10;                                        // R7
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [127:0] d, output logic e,
                         output logic v);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; d = rsp_data; e = rsp_err;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0]  r;
    logic [127:0] d;
    logic         e, v;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0, "R1", "rsp_valid", 128'(rsp_valid), 0);
    chk(req_ready == 1, "R1", "req_ready", 128'(req_ready), 1);
    reg_read(4'h0, r);
    chk(r == 0, "R1", "ctrl at reset", 128'(r), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 full page-address sweep while idle
    reg_write(4'h0, 32'h1);
    for (int a = 0; a < 256; a++) begin
      do_read(8'(a), d, e, v);
      chk(v == 1, "R8", "valid one cycle after accept", 128'(v), 1);
      chk(e == 0 && d == exp_page(8'(a)), "R3", "idle page data", d, exp_page(8'(a)));
    end

    // R2 R4 R5 R6 R7 R11 sweep over control, hv and mask
    for (int c = 0; c < 32; c++) begin
      for (int hv = 0; hv < 2; hv++) begin
        for (int m = 0; m < 16; m++) begin
          reg_write(4'h0, 32'(c));
          hv_active = hv[0]; op_part_mask = 4'(m);
          for (int p = 0; p < 4; p++) begin
            logic [7:0] a;
            logic [1:0] x;
            a = {2'(p), 6'(p * 13 + c + m)};
            x = exp_acc(5'(c), hv[0], 4'(m), 2'(p));
            do_read(a, d, e, v);
            chk(v == 1 && e == x[1], "R5", "sweep error bit", 128'(e), 128'(x[1]));
            chk(d == (x[1] ? 128'h0 : exp_page(a)), "R4", "sweep data", d,
                x[1] ? 128'h0 : exp_page(a));
            reg_read(4'h0, r);
            chk(r[8] == x[0], "R7", "sticky after sweep read", 128'(r[8]), 128'(x[0]));
            if (r[8]) begin
              reg_write(4'h0, 32'(c) | 32'h100);
              reg_read(4'h0, r);
              chk(r[8] == 0, "R9", "w1c clears sticky", 128'(r[8]), 0);
            end
          end
        end
      end
    end

    // R9 write 0 keeps sticky, same-edge set wins, clear wins over harmless read
    reg_write(4'h0, 32'h3);           // en + pgm
    hv_active = 1; op_part_mask = 4'b0001;
    do_read(8'h05, d, e, v);
    reg_write(4'h0, 32'h3);
    reg_read(4'h0, r);
    chk(r[8] == 1, "R9", "write of 0 keeps sticky", 128'(r[8]), 1);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 4'h0; reg_wdata = 32'h103;
    req_valid = 1; req_addr = 8'h07;
    @(negedge clk);
    reg_wr_en = 0; req_valid = 0;
    chk(rsp_err == 1, "R5", "same-edge conflict error", 128'(rsp_err), 1);
    reg_read(4'h0, r);
    chk(r[8] == 1, "R9", "set wins over same-edge clear", 128'(r[8]), 1);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 4'h0; reg_wdata = 32'h103;
    req_valid = 1; req_addr = 8'hC1;
    @(negedge clk);
    reg_wr_en = 0; req_valid = 0;
    chk(rsp_err == 0 && rsp_data == exp_page(8'hC1), "R4", "harmless read", rsp_data,
        exp_page(8'hC1));
    reg_read(4'h0, r);
    chk(r[8] == 0, "R9", "clear with harmless read", 128'(r[8]), 0);

    // R10 status and unmapped space
    hv_active = 1; op_part_mask = 4'b1010;
    reg_read(4'h4, r);
    chk(r == 32'h1A, "R10", "status mirror", 128'(r), 128'h1A);
    reg_read(4'h8, r);
    chk(r == 0, "R10", "unmapped read 0x8", 128'(r), 0);
    reg_read(4'h1, r);
    chk(r == 0, "R10", "unaligned read", 128'(r), 0);
    reg_read(4'hC, r);
    chk(r == 0, "R10", "unmapped read 0xC", 128'(r), 0);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_write(4'h4, 32'hFFFF_FFFF);
    reg_write(4'h2, 32'hFFFF_FFFF);
    reg_read(4'h0, r);
    chk(r == 32'h3, "R10", "ctrl untouched by other writes", 128'(r), 128'h3);

    // R8 back-pressure
    reg_write(4'h0, 32'h1);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 8'h2A;
    @(negedge clk);
    req_addr = 8'h6B;
    for (int i = 0; i < 3; i++) begin
      chk(rsp_valid == 1 && req_ready == 0, "R8", "stall ready low", 128'(req_ready), 0);
      chk(rsp_data == exp_page(8'h2A), "R8", "held data", rsp_data, exp_page(8'h2A));
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1 && rsp_data == exp_page(8'h6B), "R8", "second after release",
        rsp_data, exp_page(8'h6B));
    @(negedge clk);
    chk(rsp_valid == 0, "R8", "drained", 128'(rsp_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule